// File: doc/BRIEF.md
# Priority Break Controller

This block decides when a running program may be interrupted by one of sixteen service channels, and when it may, it drives the memory traffic that saves the processor state. Each channel can be raised in three ways: by a device that has finished its work, by the program itself, or by an external line. Requests are latched until served. At every instruction boundary the controller compares the most urgent waiting channel with the level now in service. It breaks only when the waiting channel is strictly more urgent.

A break produces four consecutive cycles of output. The first three are memory writes into the channel's private four-word block: the accumulator, the in-out register, and one word that packs the program counter with the index register. The fourth cycle presents the address of the channel's vector word, which the processor fetches as its next instruction. Active levels are kept as a set of bits, so breaks can nest. A return strobe closes the most urgent open level and lets the next one down take effect again.

Top module: `brk_seq_ctrl`

## Requirements
- R1: After a synchronous reset, `mem_wr`, `fetch_valid` and `busy` are 0 and `active_lvl` is all zero.
- R2: A one-cycle pulse on `dev_done[n]`, `sw_req[n]` or `ext_req[n]` latches a request for channel n, which stays pending until that channel is broken to.
- R3: A break starts only on a cycle where `insn_end` is 1 and `busy` is 0; without such a cycle, pending requests produce no memory activity.
- R4: A break to channel n writes on three consecutive cycles, starting the cycle after the boundary: address 4n+BASE gets the accumulator, 4n+BASE+1 gets the in-out register, and 4n+BASE+2 gets the packed word. The values written are those present on the boundary cycle.
- R5: In the packed word, the program counter occupies bits 35:18 and the index register occupies bits 17:0.
- R6: On the cycle after the third write, `fetch_valid` is 1 for exactly one cycle with `fetch_addr` = 4n+BASE+3, and `mem_wr` is 0 on that cycle.
- R7: When several channels are eligible at once, the lowest-numbered channel is served first (channel 0 is the most urgent).
- R8: A pending channel is eligible only if its number is lower than every bit set in `active_lvl`. Otherwise it stays pending and is served after the blocking levels return.
- R9: A break to channel n sets `active_lvl[n]`, and a more urgent channel can break a level that is already in service (nesting).
- R10: A `ret_strobe` accepted while idle clears the lowest-numbered set bit of `active_lvl`. With no bit set, it has no effect.
- R11: `insn_end` and `ret_strobe` are ignored while `busy` is 1. `busy` is 1 during the three write cycles and the fetch cycle.
- R12: When `ret_strobe` and `insn_end` arrive on the same idle cycle, the return is applied first and eligibility is judged against the levels that remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_done | input | NCH | Device-completion request pulses, one per channel |
| sw_req | input | NCH | Program-issued request pulses, one per channel |
| ext_req | input | NCH | External-line request pulses, one per channel |
| insn_end | input | 1 | Instruction boundary strobe |
| ret_strobe | input | 1 | Return-from-level strobe |
| acc_in | input | 2*HW | Accumulator contents |
| io_in | input | 2*HW | In-out register contents |
| pc_in | input | HW | Program counter |
| ix_in | input | HW | Index register |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 2*HW | Memory write data |
| fetch_valid | output | 1 | Vector fetch request |
| fetch_addr | output | AW | Vector fetch address |
| busy | output | 1 | Save sequence in progress |
| active_lvl | output | NCH | Open service levels, one bit per channel |

## Verification
The bench targets these corner cases, each with the fault it would expose:
- A request less urgent than the open level arrives at a boundary. A controller that ignored the active set would nest wrongly and emit an unexpected write burst.
- A return and a boundary fall on the same cycle. A design that judged eligibility against the old levels would miss a break that should happen.
- Return and boundary strobes are pulsed in the middle of a save burst. A design that accepted them would drop a level or start an overlapping sequence.
- Channels 0 and 15 are exercised at the address extremes, and the inputs change right after each boundary. This catches swapped halves in the packed word and values taken late instead of captured at the boundary.

// File: rtl/brk_pkg.sv
package brk_pkg;

  // Save-sequence phase; each name says what the outputs show in that phase.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR_AC = 3'd1,
    ST_WR_IO = 3'd2,
    ST_WR_PX = 3'd3,
    ST_FETCH = 3'd4
  } brk_st_e;

  // Word offsets within a channel's four-word block.
  localparam int unsigned OFS_AC = 0;
  localparam int unsigned OFS_IO = 1;
  localparam int unsigned OFS_PX = 2;
  localparam int unsigned OFS_VEC = 3;

endpackage

// File: rtl/brk_req_latch.sv
module brk_req_latch #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] dev_done,
  input  logic [NCH-1:0] sw_req,
  input  logic [NCH-1:0] ext_req,
  input  logic [NCH-1:0] take_oh,
  output logic [NCH-1:0] pend
);

  logic [NCH-1:0] pend_q;

  // A fresh request on the same cycle as a take re-arms the channel.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~take_oh) | dev_done | sw_req | ext_req;
  end

  assign pend = pend_q;

endmodule

// File: rtl/brk_prio_pick.sv
module brk_prio_pick #(
  parameter int unsigned NCH = 16,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] vec,
  output logic [NCH-1:0] oh,
  output logic [IW-1:0]  idx,
  output logic           valid
);

  // Fixed chain: bit 0 wins over everything above it.
  for (genvar i = 0; i < NCH; i++) begin : g_chain
    if (i == 0) begin : g_head
      assign oh[i] = vec[i];
    end else begin : g_link
      assign oh[i] = vec[i] & ~(|vec[i-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (oh[i]) idx = IW'(i);
    end
  end

  assign valid = |vec;

endmodule

// File: rtl/brk_level_stack.sv
module brk_level_stack #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ret_en,
  input  logic [NCH-1:0] push_oh,
  output logic [NCH-1:0] allow_mask,
  output logic [NCH-1:0] active
);

  logic [NCH-1:0] act_q;
  logic [NCH-1:0] top_oh;
  logic [NCH-1:0] after_ret;
  logic [NCH-1:0] after_top;

  // Most urgent open level = lowest set bit.
  assign top_oh    = act_q & (~act_q + NCH'(1));
  assign after_ret = ret_en ? (act_q & ~top_oh) : act_q;
  assign after_top = after_ret & (~after_ret + NCH'(1));

  // Channels strictly below the remaining top level may break in.
  assign allow_mask = (after_ret == '0) ? '1 : (after_top - NCH'(1));

  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else     act_q <= after_ret | push_oh;
  end

  assign active = act_q;

endmodule

// File: rtl/brk_save_fsm.sv
module brk_save_fsm
  import brk_pkg::*;
#(
  parameter int unsigned NCH  = 16,
  parameter int unsigned HW   = 18,
  parameter int unsigned AW   = 18,
  parameter int unsigned BASE = 0,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned DW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [IW-1:0] ch_idx,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] io_in,
  input  logic [HW-1:0] pc_in,
  input  logic [HW-1:0] ix_in,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  output logic          busy
);

  brk_st_e       st_q;
  logic [AW-1:0] base_q;
  logic [DW-1:0] io_q;
  logic [DW-1:0] px_q;
  logic [AW-1:0] base_n;

  assign base_n = AW'(BASE) + AW'({ch_idx, 2'b00});

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      mem_wr      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      fetch_valid <= 1'b0;
      fetch_addr  <= '0;
      base_q      <= '0;
      io_q        <= '0;
      px_q        <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            mem_wr    <= 1'b1;
            mem_addr  <= base_n + AW'(OFS_AC);
            mem_wdata <= acc_in;
            io_q      <= io_in;
            px_q      <= {pc_in, ix_in};
            base_q    <= base_n;
            st_q      <= ST_WR_AC;
          end
        end
        ST_WR_AC: begin
          mem_addr  <= base_q + AW'(OFS_IO);
          mem_wdata <= io_q;
          st_q      <= ST_WR_IO;
        end
        ST_WR_IO: begin
          mem_addr  <= base_q + AW'(OFS_PX);
          mem_wdata <= px_q;
          st_q      <= ST_WR_PX;
        end
        ST_WR_PX: begin
          mem_wr      <= 1'b0;
          fetch_valid <= 1'b1;
          fetch_addr  <= base_q + AW'(OFS_VEC);
          st_q        <= ST_FETCH;
        end
        ST_FETCH: begin
          fetch_valid <= 1'b0;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/brk_seq_ctrl.sv
module brk_seq_ctrl #(
  parameter int unsigned NCH  = 16,
  parameter int unsigned HW   = 18,
  parameter int unsigned AW   = 18,
  parameter int unsigned BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    dev_done,
  input  logic [NCH-1:0]    sw_req,
  input  logic [NCH-1:0]    ext_req,
  input  logic              insn_end,
  input  logic              ret_strobe,
  input  logic [2*HW-1:0]   acc_in,
  input  logic [2*HW-1:0]   io_in,
  input  logic [HW-1:0]     pc_in,
  input  logic [HW-1:0]     ix_in,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [2*HW-1:0]   mem_wdata,
  output logic              fetch_valid,
  output logic [AW-1:0]     fetch_addr,
  output logic              busy,
  output logic [NCH-1:0]    active_lvl
);

  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] pend;
  logic [NCH-1:0] allow_mask;
  logic [NCH-1:0] eligible;
  logic [NCH-1:0] win_oh;
  logic [NCH-1:0] take_oh;
  logic [IW-1:0]  win_idx;
  logic           win_valid;
  logic           idle;
  logic           ret_en;
  logic           take;

  assign idle     = ~busy;
  assign ret_en   = ret_strobe & idle;
  assign eligible = pend & allow_mask;
  assign take     = insn_end & idle & win_valid;
  assign take_oh  = take ? win_oh : '0;

  brk_req_latch #(.NCH(NCH)) u_req (
    .clk      (clk),
    .rst      (rst),
    .dev_done (dev_done),
    .sw_req   (sw_req),
    .ext_req  (ext_req),
    .take_oh  (take_oh),
    .pend     (pend)
  );

  brk_level_stack #(.NCH(NCH)) u_lvl (
    .clk        (clk),
    .rst        (rst),
    .ret_en     (ret_en),
    .push_oh    (take_oh),
    .allow_mask (allow_mask),
    .active     (active_lvl)
  );

  brk_prio_pick #(.NCH(NCH)) u_pick (
    .vec   (eligible),
    .oh    (win_oh),
    .idx   (win_idx),
    .valid (win_valid)
  );

  brk_save_fsm #(.NCH(NCH), .HW(HW), .AW(AW), .BASE(BASE)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (take),
    .ch_idx      (win_idx),
    .acc_in      (acc_in),
    .io_in       (io_in),
    .pc_in       (pc_in),
    .ix_in       (ix_in),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .busy        (busy)
  );

endmodule

// File: rtl/brk_seq_chk.sv
module brk_seq_chk #(
  parameter int unsigned NCH = 16,
  parameter int unsigned AW  = 18
) (
  input logic           clk,
  input logic           rst,
  input logic           insn_end,
  input logic           ret_strobe,
  input logic           mem_wr,
  input logic [AW-1:0]  mem_addr,
  input logic           fetch_valid,
  input logic [AW-1:0]  fetch_addr,
  input logic           busy,
  input logic [NCH-1:0] active_lvl
);

  // R3: no memory activity outside a save sequence
  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_wr && !fetch_valid));

  // R4: first two writes are followed by the next consecutive slot
  p_write_walk_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_addr[1:0] != 2'd2) |=> (mem_wr && mem_addr == $past(mem_addr) + AW'(1)));

  // R6: the third write is followed by the vector fetch alone
  p_fetch_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_addr[1:0] == 2'd2) |=> (fetch_valid && !mem_wr && fetch_addr == $past(mem_addr) + AW'(1)));

  // R6: fetch and write never share a cycle; fetch lasts one cycle
  p_fetch_alone_r6: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> !mem_wr);
  p_fetch_single_r6: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> !fetch_valid);

  // R10: an accepted return removes exactly one open level
  p_ret_pop_r10: assert property (@(posedge clk) disable iff (rst)
    (ret_strobe && !busy && !insn_end && active_lvl != '0)
      |=> ($countones(active_lvl) == $countones($past(active_lvl)) - 1));

  // R10: a return with nothing open changes nothing
  p_ret_empty_r10: assert property (@(posedge clk) disable iff (rst)
    (ret_strobe && !busy && !insn_end && active_lvl == '0) |=> (active_lvl == '0));

  // R11: the level set is frozen while a sequence runs
  p_busy_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(active_lvl));

endmodule

bind brk_seq_ctrl brk_seq_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .insn_end    (insn_end),
  .ret_strobe  (ret_strobe),
  .mem_wr      (mem_wr),
  .mem_addr    (mem_addr),
  .fetch_valid (fetch_valid),
  .fetch_addr  (fetch_addr),
  .busy        (busy),
  .active_lvl  (active_lvl)
);

// File: tb/test_brk_seq_ctrl.sv
`timescale 1ns/1ps
module test_brk_seq_ctrl;

  localparam int NCH = 16;
  localparam int HW  = 18;
  localparam int AW  = 18;
  localparam int DW  = 2 * HW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NCH-1:0] dev_done = '0, sw_req = '0, ext_req = '0;
  logic          insn_end = 1'b0, ret_strobe = 1'b0;
  logic [DW-1:0] acc_in = '0, io_in = '0;
  logic [HW-1:0] pc_in = '0, ix_in = '0;
  logic          mem_wr, fetch_valid, busy;
  logic [AW-1:0] mem_addr, fetch_addr;
  logic [DW-1:0] mem_wdata;
  logic [NCH-1:0] active_lvl;

  always #10 clk = ~clk;  // 50 MHz

  brk_seq_ctrl #(.NCH(NCH), .HW(HW), .AW(AW), .BASE(0)) i_brk_seq_ctrl (
    .clk(clk), .rst(rst), .dev_done(dev_done), .sw_req(sw_req), .ext_req(ext_req),
    .insn_end(insn_end), .ret_strobe(ret_strobe), .acc_in(acc_in), .io_in(io_in),
    .pc_in(pc_in), .ix_in(ix_in), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .busy(busy), .active_lvl(active_lvl)
  );

  typedef struct packed {
    logic          is_fetch;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;

  // Scoreboard monitor: every output event is matched against the queue.
  always @(negedge clk) begin
    if (!rst && (mem_wr || fetch_valid)) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected event wr=%0b fetch=%0b addr=%h, expected none",
                 mem_wr, fetch_valid, mem_wr ? mem_addr : fetch_addr);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e.is_fetch) begin
          if (!fetch_valid || mem_wr || fetch_addr !== e.addr) begin
            errors++;
            $display("FAIL %s fetch: got fetch=%0b wr=%0b addr=%h, expected fetch addr=%h",
                     t, fetch_valid, mem_wr, fetch_addr, e.addr);
          end
        end else begin
          if (!mem_wr || mem_addr !== e.addr || mem_wdata !== e.data) begin
            errors++;
            $display("FAIL %s write: got wr=%0b addr=%h data=%h, expected addr=%h data=%h",
                     t, mem_wr, mem_addr, mem_wdata, e.addr, e.data);
          end
        end
      end
    end
  end

  task automatic push_break(input int ch, input logic [DW-1:0] a, input logic [DW-1:0] io,
                            input logic [HW-1:0] pc, input logic [HW-1:0] ix, input string t);
    logic [AW-1:0] b;
    b = AW'(ch * 4);
    exp_q.push_back('{1'b0, b,           a});          tag_q.push_back({t, "/R4 acc"});
    exp_q.push_back('{1'b0, b + AW'(1),  io});         tag_q.push_back({t, "/R4 io"});
    exp_q.push_back('{1'b0, b + AW'(2),  {pc, ix}});   tag_q.push_back({t, "/R5 packed"});
    exp_q.push_back('{1'b1, b + AW'(3),  {DW{1'b0}}}); tag_q.push_back({t, "/R6 vector"});
  endtask

  task automatic pulse_req(input logic [NCH-1:0] d, input logic [NCH-1:0] s, input logic [NCH-1:0] x);
    @(negedge clk);
    dev_done = d; sw_req = s; ext_req = x;
    @(negedge clk);
    dev_done = '0; sw_req = '0; ext_req = '0;
  endtask

  // Boundary strobe; exp_ch < 0 means no break is expected.
  task automatic boundary(input int exp_ch, input logic with_ret, input logic [DW-1:0] a,
                          input logic [DW-1:0] io, input logic [HW-1:0] pc,
                          input logic [HW-1:0] ix, input string t);
    if (exp_ch >= 0) push_break(exp_ch, a, io, pc, ix, t);
    @(negedge clk);
    insn_end = 1'b1; ret_strobe = with_ret;
    acc_in = a; io_in = io; pc_in = pc; ix_in = ix;
    @(negedge clk);
    insn_end = 1'b0; ret_strobe = 1'b0;
    acc_in = ~a; io_in = ~io; pc_in = ~pc; ix_in = ~ix;  // late change must not be written
    repeat (5) @(negedge clk);
  endtask

  task automatic do_ret();
    @(negedge clk);
    ret_strobe = 1'b1;
    @(negedge clk);
    ret_strobe = 1'b0;
  endtask

  task automatic check_act(input logic [NCH-1:0] exp, input string t);
    checks++;
    if (active_lvl !== exp) begin
      errors++;
      $display("FAIL %s active_lvl: got %h, expected %h", t, active_lvl, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (mem_wr !== 1'b0 || fetch_valid !== 1'b0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: got wr=%0b fetch=%0b busy=%0b, expected 0 0 0",
               mem_wr, fetch_valid, busy);
    end
    check_act('0, "R1");

    // R2 program request, R3 no break before a boundary
    pulse_req('0, 16'h0020, '0);
    repeat (4) @(negedge clk);
    boundary(5, 1'b0, 36'h1_2345_6789, 36'hA_BCDE_F012, 18'h2A5A5, 18'h1F0F0, "R2 sw ch5");
    check_act(16'h0020, "R9 open ch5");

    // R8 less urgent device request waits
    pulse_req(16'h0200, '0, '0);
    boundary(-1, 1'b0, 36'h0, 36'h0, 18'h0, 18'h0, "R8");
    check_act(16'h0020, "R8 ch9 blocked");

    // R9 nesting via external line on ch2
    pulse_req('0, '0, 16'h0004);
    boundary(2, 1'b0, 36'hF_0000_0001, 36'h0_FFFF_FFFE, 18'h00001, 18'h3FFFF, "R9 ext ch2");
    check_act(16'h0024, "R9 nested");

    // R10 return pops ch2, ch9 still blocked by ch5
    do_ret();
    check_act(16'h0020, "R10 pop ch2");
    boundary(-1, 1'b0, 36'h0, 36'h0, 18'h0, 18'h0, "R8");
    do_ret();
    check_act('0, "R10 pop ch5");
    boundary(9, 1'b0, 36'h5_5555_5555, 36'hA_AAAA_AAAA, 18'h12345, 18'h2ABCD, "R8 ch9 served");
    check_act(16'h0200, "R8 ch9 open");
    do_ret();

    // R7 simultaneous requests: ch3 before ch7
    pulse_req(16'h0008, 16'h0080, '0);
    boundary(3, 1'b0, 36'h0_0000_0033, 36'h0_0000_0003, 18'h00033, 18'h00003, "R7 ch3 first");
    check_act(16'h0008, "R7");
    do_ret();
    boundary(7, 1'b0, 36'h0_0000_0077, 36'h0_0000_0007, 18'h00077, 18'h00007, "R7 ch7 next");
    do_ret();
    check_act('0, "R7 done");

    // R11 strobes during busy are ignored
    pulse_req('0, 16'h0400, '0);
    push_break(10, 36'h1_0101_0101, 36'h2_0202_0202, 18'h10101, 18'h20202, "R11 ch10");
    @(negedge clk);
    insn_end = 1'b1;
    acc_in = 36'h1_0101_0101; io_in = 36'h2_0202_0202; pc_in = 18'h10101; ix_in = 18'h20202;
    @(negedge clk);
    ret_strobe = 1'b1;           // design now busy
    sw_req = 16'h0002;           // pending ch1 must not break mid-sequence
    @(negedge clk);
    ret_strobe = 1'b0; insn_end = 1'b0; sw_req = '0;
    repeat (5) @(negedge clk);
    check_act(16'h0400, "R11 ret ignored");
    boundary(1, 1'b0, 36'h0_1111_1111, 36'h0_2222_2222, 18'h01111, 18'h02222, "R11 ch1 later");
    check_act(16'h0402, "R11 ch1 nested");
    do_ret();

    // R12 return and boundary together
    pulse_req('0, 16'h1000, '0);
    boundary(12, 1'b1, 36'hC_CCCC_CCCC, 36'h3_3333_3333, 18'h0CCCC, 18'h33333, "R12 ch12");
    check_act(16'h1000, "R12");
    do_ret();
    check_act('0, "R12 closed");

    // R10 return on empty set; R3 boundary with nothing pending
    do_ret();
    check_act('0, "R10 empty");
    boundary(-1, 1'b0, 36'h0, 36'h0, 18'h0, 18'h0, "R3");

    // Address extremes: ch15 then ch0 nesting
    pulse_req('0, 16'h8000, '0);
    boundary(15, 1'b0, 36'hF_FFFF_FFFF, 36'h0_0000_0000, 18'h3FFFF, 18'h00000, "R4 ch15");
    pulse_req(16'h0001, '0, '0);
    boundary(0, 1'b0, 36'h0_0000_0000, 36'hF_FFFF_FFFF, 18'h00000, 18'h3FFFF, "R5 ch0");
    check_act(16'h8001, "R9 ch0 over ch15");
    do_ret();
    check_act(16'h8000, "R10 pop ch0");
    do_ret();
    check_act('0, "R10 pop ch15");

    // R6: every expected event consumed
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 missing events: got %0d left, expected 0", exp_q.size());
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule